// File: doc/BRIEF.md
# Multi-format serial audio port

This block is a slave-side serial audio port for a stereo codec datapath. An external master supplies the bit clock and the frame clock. The port uses them to send DAC samples out on a serial data pin and to collect ADC samples from a serial data pin. All three serial pins, and the master clock, are oversampled in the block's own system clock. A two-bit synchronizer and an edge detector sit on each of them, so the bit clock has to run well below the system clock.

A single shifting engine handles four framing styles, chosen by a 2-bit code: standard I2S, left-justified, right-justified and DSP/PCM. A 2-bit word-length code picks 16, 24 or 32 bits per sample. Samples on the parallel side are right-aligned in 32-bit buses. On the transmit side a one-entry staging register holds a left/right pair. The pair moves into the shifter when the next frame starts. If no pair is waiting, the port sends zeros and records an underrun. On the receive side, each finished word is handed over with a one-cycle strobe and a channel tag.

The block also checks that the master clock is present at the right ratio. It counts master-clock rising edges over each frame and flags any frame whose count is not 256.

Top module: `serial_audio_port`

## Requirements
- R1: After reset, `sdout_o`, `rx_valid_o`, `underrun_o` and `mclk_err_o` are 0, and `tx_ready_o` is 1.
- R2: With format code 0 (standard I2S), the port behaves as follows:
  - The frame clock is low for the left channel and high for the right channel.
  - Each word's MSB occupies the second bit-clock slot after a frame-clock change.
  - The remaining bits follow in order down to the LSB.
  - Each half-frame must hold at least one slot more than the word length.
- R3: With format code 1 (left-justified), each word's MSB occupies the first bit-clock slot after a frame-clock change. The channel mapping is the same as in R2.
- R4: With format code 2 (right-justified), each word's LSB occupies the last bit-clock slot before the next frame-clock change. The half-frame length used for this is the one measured over the previous half-frame.
- R5: With format code 3 (DSP/PCM), a rising frame clock marks the start of a frame. The frame clock is a pulse one bit clock wide. The slot in which the pulse is high carries the left MSB. The right word follows directly after the left LSB.
- R6: Word-length code 0 selects 16 bits, code 1 selects 24 bits, and codes 2 and 3 select 32 bits. Parallel samples are right-aligned, and transmit bits above the word length are ignored.
- R7: During bit-clock slots outside any word, `sdout_o` is 0. The `sdin_i` level in those slots has no effect on received words.
- R8: Each received word is presented once, as follows:
  - `rx_valid_o` is high for one cycle.
  - `rx_chan_o` is 0 for left and 1 for right.
  - `rx_data_o` holds the word right-aligned, with zeros above the word length.
- R9: Transmit staging works as follows:
  - `tx_ready_o` is high while the one-entry staging register is empty.
  - A pair accepted with `tx_valid_o`/`tx_ready_o` drops `tx_ready_o` on the next cycle.
  - The accepted pair is transmitted in the frame that starts next.
- R10: When a frame starts with no staged pair, both words of that frame are sent as zeros and `underrun_o` goes high. `underrun_o` stays high until reset.
- R11: At each frame start after the first one, `mclk_err_o` shows whether the frame just ended held a number of master-clock rising edges other than 256. It clears again after a frame with exactly 256.
- R12: `sdout_o` changes only after a bit-clock falling edge. `sdin_i` is sampled at bit-clock rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample all serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_i | input | 1 | Master clock being checked for presence and ratio |
| bclk_i | input | 1 | Bit clock from the external master |
| lrck_i | input | 1 | Frame clock (channel select, or frame pulse in DSP/PCM) |
| sdin_i | input | 1 | Serial ADC data into the port |
| sdout_o | output | 1 | Serial DAC data out of the port |
| fmt_i | input | 2 | Framing select: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP/PCM |
| wlen_i | input | 2 | Word length: 0 = 16, 1 = 24, 2/3 = 32 bits |
| tx_valid_i | input | 1 | Transmit pair offered |
| tx_ready_o | output | 1 | Staging register empty, pair can be taken |
| tx_left_i | input | 32 | Left transmit sample, right-aligned |
| tx_right_i | input | 32 | Right transmit sample, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for a completed received word |
| rx_chan_o | output | 1 | Channel of the received word (0 left, 1 right) |
| rx_data_o | output | 32 | Received word, right-aligned |
| underrun_o | output | 1 | Sticky transmit underrun flag |
| mclk_err_o | output | 1 | Master-clock count of the last frame differed from 256 |

## Verification
The embedded assertions guard the following properties on every cycle:
- the serial output moves only after a detected bit-clock fall;
- the receive strobe is a single cycle that follows a detected rising edge;
- the staging handshake empties and fills correctly;
- the underrun flag stays set;
- the master-clock flag changes only at frame starts.

Only the bench scenarios can show the slot placement of each framing style and word length. The same holds for the zeros in idle slots and for right-justified alignment to the measured half-frame. The bench also covers the zero frame after a missed pair and the detection and recovery of a wrong master-clock ratio.

// File: rtl/serial_audio_port.sv
module serial_audio_port #(
  parameter int SLOT_W     = 8,
  parameter int MCLK_RATIO = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mclk_i,
  input  logic        bclk_i,
  input  logic        lrck_i,
  input  logic        sdin_i,
  output logic        sdout_o,
  input  logic [1:0]  fmt_i,
  input  logic [1:0]  wlen_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  input  logic [31:0] tx_left_i,
  input  logic [31:0] tx_right_i,
  output logic        rx_valid_o,
  output logic        rx_chan_o,
  output logic [31:0] rx_data_o,
  output logic        underrun_o,
  output logic        mclk_err_o
);
  localparam int DW = 32;
  localparam int IW = $clog2(DW);
  localparam int MW = $clog2(MCLK_RATIO) + 2;

  logic [2:0] bclk_s, mclk_s;
  logic [1:0] lrck_s, sdin_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_s <= '0;
      mclk_s <= '0;
      lrck_s <= '1;
      sdin_s <= '0;
    end else begin
      bclk_s <= {bclk_s[1:0], bclk_i};
      mclk_s <= {mclk_s[1:0], mclk_i};
      lrck_s <= {lrck_s[0], lrck_i};
      sdin_s <= {sdin_s[0], sdin_i};
    end
  end

  wire rise  = bclk_s[1] & ~bclk_s[2];
  wire fall  = ~bclk_s[1] & bclk_s[2];
  wire mrise = mclk_s[1] & ~mclk_s[2];
  wire lr    = lrck_s[1];
  wire sd    = sdin_s[1];
  wire dsp   = (fmt_i == 2'd3);

  wire [SLOT_W-1:0] wl = (wlen_i == 2'd0) ? SLOT_W'(16) :
                         (wlen_i == 2'd1) ? SLOT_W'(24) : SLOT_W'(DW);

  logic              lr_last, locked, ch, act, full;
  logic [SLOT_W-1:0] slot, half_len;
  logic [IW-1:0]     idx;
  logic [DW-1:0]     cur_l, cur_r, stg_l, stg_r;
  logic [DW-2:0]     sh;
  logic [MW-1:0]     mcnt;
  logic              mseen;

  wire ev_any  = dsp ? (lr & ~lr_last) : (lr ^ lr_last);
  wire ev_left = ev_any & (dsp | ~lr);

  wire [SLOT_W-1:0] slot_inc = (&slot) ? slot : slot + 1'b1;
  wire [SLOT_W-1:0] nslot    = ev_any ? '0 : slot_inc;
  wire              nch      = dsp ? (nslot >= wl) : lr;

  logic [SLOT_W-1:0] start;
  always_comb begin
    case (fmt_i)
      2'd0:    start = SLOT_W'(1);
      2'd1:    start = '0;
      2'd2:    start = (half_len > wl) ? half_len - wl : '0;
      default: start = nch ? wl : '0;
    endcase
  end

  wire [SLOT_W-1:0] rel  = nslot - start;
  wire              nact = (locked | ev_any) && (nslot >= start) && (rel < wl);
  wire [IW-1:0]     nidx = IW'(wl - 1'b1 - rel);

  wire [DW-1:0] new_l = full ? stg_l : '0;
  wire [DW-1:0] new_r = full ? stg_r : '0;
  wire [DW-1:0] word  = nch ? (ev_left ? new_r : cur_r) : (ev_left ? new_l : cur_l);

  wire [DW-1:0] sh_nx = (idx == IW'(wl - 1'b1)) ? {{(DW-1){1'b0}}, sd} : {sh, sd};

  assign tx_ready_o = ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_last    <= 1'b1;
      locked     <= 1'b0;
      slot       <= '0;
      half_len   <= SLOT_W'(DW);
      ch         <= 1'b0;
      act        <= 1'b0;
      idx        <= '0;
      sdout_o    <= 1'b0;
      cur_l      <= '0;
      cur_r      <= '0;
      stg_l      <= '0;
      stg_r      <= '0;
      full       <= 1'b0;
      underrun_o <= 1'b0;
      mcnt       <= '0;
      mseen      <= 1'b0;
      mclk_err_o <= 1'b0;
      sh         <= '0;
      rx_valid_o <= 1'b0;
      rx_chan_o  <= 1'b0;
      rx_data_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (mrise && !(&mcnt)) mcnt <= mcnt + 1'b1;
      if (fall) begin
        lr_last <= lr;
        slot    <= nslot;
        ch      <= nch;
        act     <= nact;
        idx     <= nidx;
        sdout_o <= nact & word[nidx];
        if (ev_any) begin
          locked   <= 1'b1;
          half_len <= slot_inc;
        end
        if (ev_left) begin
          cur_l <= new_l;
          cur_r <= new_r;
          full  <= 1'b0;
          if (!full) underrun_o <= 1'b1;
          mclk_err_o <= mseen && (mcnt != MW'(MCLK_RATIO));
          mseen      <= 1'b1;
          mcnt       <= mrise ? MW'(1) : '0;
        end
      end
      if (tx_valid_i && !full) begin
        full  <= 1'b1;
        stg_l <= tx_left_i;
        stg_r <= tx_right_i;
      end
      if (rise && act) begin
        sh <= sh_nx[DW-2:0];
        if (idx == '0) begin
          rx_valid_o <= 1'b1;
          rx_chan_o  <= ch;
          rx_data_o  <= sh_nx;
        end
      end
    end
  end

  // R12
  sdout_only_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdout_o));

  // R8
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  // R12
  rx_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> $past(rise));

  // R9
  stage_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  // R10
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |=> underrun_o);

  // R11
  mclk_flag_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall && ev_left) |=> $stable(mclk_err_o));
endmodule

// File: tb/serial_audio_port_test.sv
module serial_audio_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mclk = 1'b0, bclk = 1'b1, lrck = 1'b1, sdin = 1'b0;
  logic [1:0] fmt_v = 2'd0, wl_code = 2'd0;
  logic tx_valid = 1'b0;
  logic [31:0] tx_left = '0, tx_right = '0;
  logic sdout, tx_ready, rx_valid, rx_chan, underrun, mclk_err;
  logic [31:0] rx_data;

  int total = 0, bad = 0, mhalf = 2, ncap = 0, fno = 0;
  logic [31:0] cap_d [256];
  logic        cap_c [256];
  logic [31:0] cur_l, cur_r, nxt_l, nxt_r, rx_l, rx_r;

  always #2 clk = ~clk;

  always begin
    repeat (mhalf) @(negedge clk);
    mclk = ~mclk;
  end

  serial_audio_port uut (
    .clk(clk), .rst_n(rst_n), .mclk_i(mclk), .bclk_i(bclk), .lrck_i(lrck),
    .sdin_i(sdin), .sdout_o(sdout), .fmt_i(fmt_v), .wlen_i(wl_code),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_left_i(tx_left),
    .tx_right_i(tx_right), .rx_valid_o(rx_valid), .rx_chan_o(rx_chan),
    .rx_data_o(rx_data), .underrun_o(underrun), .mclk_err_o(mclk_err));

  always @(posedge clk) if (rx_valid) begin
    cap_d[ncap % 256] = rx_data;
    cap_c[ncap % 256] = rx_chan;
    ncap++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wl_of(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
  endfunction

  function automatic logic [31:0] patt(input int n);
    return (32'(n) * 32'h9E3779B9) ^ 32'h5A5A1234;
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    case (f)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // {active, bit} for slot k of a 64-slot frame
  function automatic logic [1:0] slot_bit(input logic [1:0] f, input int w, input int k,
                                          input logic [31:0] l, input logic [31:0] r);
    int s, st;
    logic c;
    if (f == 2'd3) begin
      c = (k >= w); s = k; st = c ? w : 0;
    end else begin
      c = (k >= 32); s = k % 32;
      st = (f == 2'd0) ? 1 : (f == 2'd1) ? 0 : 32 - w;
    end
    if (s >= st && s - st < w) return {1'b1, c ? r[w-1-(s-st)] : l[w-1-(s-st)]};
    return 2'b00;
  endfunction

  task automatic frame(input bit on, input bit push);
    int txe, ide, hie, base, wd;
    logic [1:0] e;
    logic so, pushed;
    logic [31:0] msk;
    wd = wl_of(wl_code);
    msk = (wd == 32) ? 32'hFFFF_FFFF : ((32'd1 << wd) - 1);
    rx_l = patt(fno * 2 + 7);
    rx_r = patt(fno * 2 + 8);
    nxt_l = patt(fno * 2 + 300);
    nxt_r = patt(fno * 2 + 301);
    fno++;
    txe = 0; ide = 0; hie = 0; pushed = 0; base = ncap;
    for (int k = 0; k < 64; k++) begin
      e = slot_bit(fmt_v, wd, k, rx_l, rx_r);
      bclk = 1'b0;
      lrck = (fmt_v == 2'd3) ? (k == 0) : (k >= 32);
      sdin = e[1] ? e[0] : (k[0] ^ k[2]);
      repeat (8) @(negedge clk);
      e = slot_bit(fmt_v, wd, k, cur_l, cur_r);
      so = sdout;
      if (so !== e[0]) begin
        if (e[1]) txe++; else ide++;
      end
      bclk = 1'b1;
      if (push && k == 4 && tx_ready) begin
        tx_left = nxt_l; tx_right = nxt_r; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        pushed = 1'b1;
        if (on) chk(tx_ready == 1'b0, "R9 ready drop", {31'd0, tx_ready}, 32'd0);
        repeat (7) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      if (sdout !== so) hie++;
    end
    if (on) begin
      chk(txe == 0, fmt_tag(fmt_v), txe, 0);
      chk(ide == 0, "R7 idle sdout", ide, 0);
      chk(hie == 0, "R12 sdout moved while bclk high", hie, 0);
      chk(ncap - base == 2, "R8 word count", ncap - base, 2);
      if (ncap - base == 2) begin
        chk(cap_d[base % 256] == (rx_l & msk) && cap_c[base % 256] == 1'b0,
            (wd == 16) ? "R8 left rx" : "R6 left rx", cap_d[base % 256], rx_l & msk);
        chk(cap_d[(base + 1) % 256] == (rx_r & msk) && cap_c[(base + 1) % 256] == 1'b1,
            (wd == 16) ? "R8 right rx" : "R6 right rx", cap_d[(base + 1) % 256], rx_r & msk);
      end
    end
    if (pushed) begin
      cur_l = nxt_l; cur_r = nxt_r;
    end else if (!push) begin
      cur_l = '0; cur_r = '0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(sdout == 1'b0, "R1 sdout", {31'd0, sdout}, 0);
    chk(tx_ready == 1'b1, "R1 ready", {31'd0, tx_ready}, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", {31'd0, rx_valid}, 0);
    chk(underrun == 1'b0 && mclk_err == 1'b0, "R1 flags", {30'd0, underrun, mclk_err}, 0);
    cur_l = patt(1); cur_r = patt(2);
    tx_left = cur_l; tx_right = cur_r; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (3) @(negedge clk);

    for (int f = 0; f < 4; f++) begin
      for (int w = 0; w < 3; w++) begin
        if (!(f == 0 && w == 2)) begin
          fmt_v = 2'(f); wl_code = 2'(w);
          frame(1'b0, 1'b1);
          frame(1'b1, 1'b1);
          frame(1'b1, 1'b1);
        end
      end
    end
    wl_code = 2'd3;
    frame(1'b1, 1'b1);

    // R11
    chk(mclk_err == 1'b0, "R11 ratio ok", {31'd0, mclk_err}, 0);
    mhalf = 3;
    frame(1'b0, 1'b1);
    frame(1'b0, 1'b1);
    chk(mclk_err == 1'b1, "R11 wrong ratio", {31'd0, mclk_err}, 1);
    mhalf = 2;
    frame(1'b0, 1'b1);
    frame(1'b0, 1'b1);
    frame(1'b0, 1'b1);
    chk(mclk_err == 1'b0, "R11 recovered", {31'd0, mclk_err}, 0);

    // R10
    fmt_v = 2'd1; wl_code = 2'd0;
    frame(1'b0, 1'b1);
    frame(1'b0, 1'b1);
    frame(1'b1, 1'b1);
    chk(underrun == 1'b0, "R10 no underrun yet", {31'd0, underrun}, 0);
    frame(1'b1, 1'b0);
    frame(1'b1, 1'b1);
    chk(underrun == 1'b1, "R10 underrun set", {31'd0, underrun}, 1);
    frame(1'b1, 1'b1);
    chk(underrun == 1'b1, "R10 underrun sticky", {31'd0, underrun}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule